// File: doc/BRIEF.md
# Per-Queue Egress Traffic Shaper

This block paces the transmit traffic of one output port that drains several priority queues. Each queue has its own programmed egress rate, in bytes per 1024 clock cycles. When the transmitter reports that a frame has left a queue, it gives the queue index and the byte count. The shaper then holds that queue ineligible for a time that grows with the frame length and falls with the queue's rate. Traffic leaves as an even stream of paced frames, not in bursts, and the long-term throughput of each queue stays at or below its programmed rate.

Each queue keeps a leaky-bucket deficit. A completed frame loads the deficit with the frame length scaled by the 1024-cycle window. The deficit then drains by the queue's rate once per cycle. A separate counter enforces the minimum inter-frame gap. The transmit scheduler reads one eligible bit per queue. Frames that are held back stay in their queues, so backpressure builds upstream. Arbitration between queues, frame storage and the MAC itself lie outside this block.

Top module: `egs_shaper`

## Requirements
- R1: After reset, every queue is eligible and stays eligible until a frame from it is reported.
- R2: A frame of any length from a queue whose rate is 0 (unlimited) makes that queue ineligible for exactly MIN_GAP (default 12) cycles, counted from the clock edge that samples the report.
- R3: A frame of N bytes from a queue with rate r > 0 makes that queue ineligible for exactly max(MIN_GAP, ceil(N*1024/r)) cycles, counted from the clock edge that samples the report.
- R4: A report for one queue never changes the eligibility of any other queue. The queue index is the binary value on `done_queue`.
- R5: The rate of queue q is taken from bits [16q+15:16q] of `rate_cfg` only at the edge that samples a report for q. A change to the rate during a hold does not alter that hold.
- R6: A report for a queue that is still ineligible restarts its hold from the new report, with the new length and the current rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_cfg | input | NUM_Q*RATE_W (64) | Per-queue rate, queue q in bits [16q+15:16q], bytes per 1024 cycles, 0 = unlimited |
| done_valid | input | 1 | A frame finished transmitting in this cycle |
| done_queue | input | $clog2(NUM_Q) (2) | Queue the finished frame came from |
| done_bytes | input | LEN_W (11) | Byte count of the finished frame |
| eligible | output | NUM_Q (4) | Per-queue permission to start a frame |

## Verification
Directed frames first run with zero rate and with zero-length frames, so that the bare minimum gap shows up apart from any rate-driven hold. Long frames at low rates then show the rate-driven hold apart from the gap. A rate that is rewritten during a hold and a repeat report during a hold separate latching at the frame boundary from continuous sampling, and a restart from an extension. Random reports on random queues, with random lengths and rates, are checked cycle by cycle against a reference model of every queue. These runs expose any crosstalk between queues and any off-by-one in the drain arithmetic.

// File: rtl/egs_pkg.sv
package egs_pkg;
    localparam int unsigned WIN_LOG = 10;

    function automatic int unsigned gap_width(input int unsigned min_gap);
        return (min_gap < 2) ? 1 : $clog2(min_gap + 1);
    endfunction
endpackage

// File: rtl/egs_event_decode.sv
module egs_event_decode #(
    parameter int unsigned NUM_Q = 4,
    localparam int unsigned QW = (NUM_Q < 2) ? 1 : $clog2(NUM_Q)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [QW-1:0]    queue_i,
    output logic [NUM_Q-1:0] load_o
);
    always_comb begin
        load_o = '0;
        for (int i = 0; i < NUM_Q; i++) begin
            if (valid_i && (queue_i == QW'(i))) load_o[i] = 1'b1;
        end
    end

    // R4
    load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_o));
endmodule

// File: rtl/egs_queue_timer.sv
module egs_queue_timer
    import egs_pkg::*;
#(
    parameter int unsigned RATE_W  = 16,
    parameter int unsigned LEN_W   = 11,
    parameter int unsigned MIN_GAP = 12,
    localparam int unsigned DEF_W = LEN_W + WIN_LOG,
    localparam int unsigned GAP_W = gap_width(MIN_GAP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [LEN_W-1:0]  bytes_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              elig_o
);
    typedef struct packed {
        logic [GAP_W-1:0]  gap;
        logic [DEF_W-1:0]  deficit;
        logic [RATE_W-1:0] rate;
    } tstate_t;

    tstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.rate = rate_i;
            st_d.gap  = GAP_W'(MIN_GAP);
            st_d.deficit = (rate_i == '0) ? '0 : {bytes_i, {WIN_LOG{1'b0}}};
        end else begin
            if (st_q.gap != '0) st_d.gap = st_q.gap - 1'b1;
            if (st_q.deficit > DEF_W'(st_q.rate))
                st_d.deficit = st_q.deficit - DEF_W'(st_q.rate);
            else
                st_d.deficit = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign elig_o = (st_q.gap == '0) && (st_q.deficit == '0);

    // R2
    hold_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !elig_o);

    // R3
    drain_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && st_q.deficit != '0) |=> (st_q.deficit < $past(st_q.deficit)));

    // R5
    rate_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.rate));
endmodule

// File: rtl/egs_shaper.sv
module egs_shaper #(
    parameter int unsigned NUM_Q   = 4,
    parameter int unsigned RATE_W  = 16,
    parameter int unsigned LEN_W   = 11,
    parameter int unsigned MIN_GAP = 12,
    localparam int unsigned QW = (NUM_Q < 2) ? 1 : $clog2(NUM_Q)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_Q*RATE_W-1:0] rate_cfg,
    input  logic                    done_valid,
    input  logic [QW-1:0]           done_queue,
    input  logic [LEN_W-1:0]        done_bytes,
    output logic [NUM_Q-1:0]        eligible
);
    logic [NUM_Q-1:0] load;
    logic             rst_seen_q;

    egs_event_decode #(.NUM_Q(NUM_Q)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (done_valid),
        .queue_i (done_queue),
        .load_o  (load)
    );

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        egs_queue_timer #(
            .RATE_W  (RATE_W),
            .LEN_W   (LEN_W),
            .MIN_GAP (MIN_GAP)
        ) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load[g]),
            .bytes_i (done_bytes),
            .rate_i  (rate_cfg[g*RATE_W +: RATE_W]),
            .elig_o  (eligible[g])
        );
    end

    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R1
    reset_eligible_chk: assert property (@(posedge clk)
        (rst_seen_q && rst_n) |-> (eligible == '1));

    // R4
    quiet_queues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_valid && eligible == '1) |=> (eligible == '1));
endmodule

// File: tb/sim_egs_shaper.sv
module sim_egs_shaper;
    localparam int NQ = 4;
    localparam int MG = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NQ*16-1:0] rate_cfg = '0;
    logic done_valid = 1'b0;
    logic [1:0] done_queue = '0;
    logic [10:0] done_bytes = '0;
    logic [NQ-1:0] eligible;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;
    int rem [NQ];
    string tag [NQ];

    always #2.5 clk = ~clk;

    egs_shaper u0 (
        .clk(clk), .rst_n(rst_n), .rate_cfg(rate_cfg),
        .done_valid(done_valid), .done_queue(done_queue),
        .done_bytes(done_bytes), .eligible(eligible)
    );

    function automatic int hold_of(input int n, input int r);
        int h;
        if (r == 0) return MG;
        h = (n * 1024 + r - 1) / r;
        return (h > MG) ? h : MG;
    endfunction

    // reference model, updated at the same edge the design samples
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) rem[q] = 0;
        end else begin
            for (int q = 0; q < NQ; q++) begin
                if (done_valid && done_queue == 2'(q))
                    rem[q] = hold_of(int'(done_bytes), int'(rate_cfg[q*16 +: 16]));
                else if (rem[q] > 0)
                    rem[q] = rem[q] - 1;
            end
        end
        if (cyc > 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check_all();
        for (int q = 0; q < NQ; q++) begin
            checks++;
            if (eligible[q] !== (rem[q] == 0)) begin
                fails++;
                $display("FAIL %s queue %0d: actual eligible=%b expected=%b", tag[q], q,
                         eligible[q], rem[q] == 0);
            end
        end
    endtask

    task automatic step(input bit v, input int q, input int n);
        @(negedge clk);
        check_all();
        done_valid = v;
        done_queue = 2'(q);
        done_bytes = 11'(n);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(0, 0, 0);
    endtask

    initial begin
        for (int q = 0; q < NQ; q++) begin rem[q] = 0; tag[q] = "R1"; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(4);                                   // R1 all eligible
        // R2: unlimited rate, long and zero-length frames
        for (int q = 0; q < NQ; q++) tag[q] = "R2";
        step(1, 0, 1500); idle(20);
        step(1, 2, 0);    idle(20);
        // R3: rate-limited, hold above and below minimum gap
        for (int q = 0; q < NQ; q++) tag[q] = "R3";
        rate_cfg[1*16 +: 16] = 16'd4096;  // 64B -> 16 cycles
        step(1, 1, 64);  idle(30);
        rate_cfg[1*16 +: 16] = 16'd65535; // 100B -> 2 cycles < gap
        step(1, 1, 100); idle(20);
        rate_cfg[3*16 +: 16] = 16'd1000;  // 1000B -> 1024 cycles
        step(1, 3, 1000); idle(1040);
        // R4: one queue busy, others reported and checked independently
        for (int q = 0; q < NQ; q++) tag[q] = "R4";
        rate_cfg[0*16 +: 16] = 16'd500;
        step(1, 0, 600); step(1, 1, 64); step(1, 2, 10); idle(1300);
        // R5: rate rewritten mid-hold does not change the hold
        for (int q = 0; q < NQ; q++) tag[q] = "R5";
        rate_cfg[2*16 +: 16] = 16'd256;   // 100B -> 400 cycles
        step(1, 2, 100); idle(10);
        rate_cfg[2*16 +: 16] = 16'd0;     // model ignores: latched at event
        idle(400);
        // R6: repeat report restarts the hold
        for (int q = 0; q < NQ; q++) tag[q] = "R6";
        rate_cfg[3*16 +: 16] = 16'd2048;  // 200B -> 100 cycles
        step(1, 3, 200); idle(50);
        step(1, 3, 40);  idle(40);
        step(1, 3, 200); idle(5);
        step(1, 3, 0);   idle(20);
        // random mix
        for (int q = 0; q < NQ; q++) tag[q] = "R3";
        void'($urandom(32'd1234));
        for (int i = 0; i < 20000; i++) begin
            if (($urandom % 16) == 0)
                rate_cfg[($urandom % NQ)*16 +: 16] =
                    (($urandom % 5) == 0) ? 16'd0 : 16'(200 + $urandom % 8000);
            if (($urandom % 6) == 0)
                step(1, int'($urandom % NQ), int'($urandom % 1519));
            else
                step(0, 0, 0);
        end
        idle(MG + 2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule